// File: doc/BRIEF.md
# In-Order Retirement Buffer with Commit-Time Memory Dispatch

This block tracks every instruction of a small dynamically scheduled pipeline from decode until it retires. Decode claims one slot per instruction, in program order, and receives the slot's tag. Later instructions use that tag as a forward reference to this instruction's result. Execution units return results by tag, in whatever order they finish. The block releases slots only from the oldest end, one per cycle. A register-writing slot that retires drives a write to the register file.

Loads and stores are never executed early. When a memory slot becomes the oldest, it is offered to an in-order load/store queue through a valid/ready handshake.

- A store frees its slot as soon as the queue accepts it.
- A load is offered once. It then stays at the oldest position until its data returns. That data goes to the register file on the same cycle. While the load waits, every younger slot is held back, even one that has already finished.

Top module: `rob_commit`

## Requirements
- R1: After reset the block is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `rf_we` and `lsq_valid` are 0.
- R2: Tags are handed out in order 0,1,...,DEPTH-1 and then wrap to 0. A slot is claimed only when `alloc_valid` and `alloc_ready` are both 1. `alloc_ready` is 0 while all DEPTH slots are held or while `rs_space` is 0.
- R3: Register-writing slots (`alloc_kind` 0) retire in allocation order, one per cycle, whatever order their results arrive in. Each retirement drives `rf_we` high for one cycle, with the slot's destination on `rf_idx` and its written-back value on `rf_data`.
- R4: A slot whose result has not yet been written back never retires. Every younger slot waits behind it.
- R5: A result write whose tag names a slot that is not held has no effect. A slot claimed later under that tag still waits for its own write.
- R6: A store (`alloc_kind` 2) at the oldest position drives `lsq_valid` with `lsq_is_store`=1, its address, its data and its tag. It retires without `rf_we` in the cycle the queue accepts it.
- R7: While `lsq_ready` is 0, the offered memory operation stays on the queue interface unchanged. The operation does not retire.
- R8: A load (`alloc_kind` 1) at the oldest position is offered with `lsq_is_store`=0 until it is accepted, and is not offered again. It then holds the oldest position until `mem_rvalid`. In that cycle it retires with `rf_we`=1, `rf_data`=`mem_rdata` and its own destination.
- R9: `mem_rvalid` has no effect unless an accepted load is waiting at the oldest position.
- R10: A claim and a retirement in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_kind | input | 2 | 0 register op, 1 load, 2 store |
| alloc_rd | input | 3 | Destination register |
| alloc_addr | input | 16 | Memory address for a load or store |
| alloc_sdata | input | 16 | Data for a store |
| rs_space | input | 1 | Paired reservation station has room |
| alloc_ready | output | 1 | A slot can be claimed this cycle |
| alloc_tag | output | 3 | Tag of the slot claimed this cycle |
| wb_valid | input | 1 | Result write-back strobe |
| wb_tag | input | 3 | Tag of the slot receiving the result |
| wb_data | input | 16 | Result value |
| rf_we | output | 1 | Register file write enable at retirement |
| rf_idx | output | 3 | Register file write index |
| rf_data | output | 16 | Register file write data |
| lsq_valid | output | 1 | Memory operation offered to the queue |
| lsq_ready | input | 1 | Queue accepts the offered operation |
| lsq_is_store | output | 1 | 1 for store, 0 for load |
| lsq_addr | output | 16 | Offered address |
| lsq_wdata | output | 16 | Offered store data |
| lsq_tag | output | 3 | Tag of the offered operation |
| mem_rvalid | input | 1 | Load data returns |
| mem_rdata | input | 16 | Returned load data |

## Verification
Register-op batches of 8, 5 and 3 slots start at shifting tag offsets, so the pointers wrap. Their results are written back in three orders: program order, reverse order and a fixed stride.

- Program order separates immediate retirement from waiting.
- Reverse order shows that nothing passes an unfinished oldest slot.
- The stride order shows that early-finishing slots never overtake.

A mixed store/register/load/register sequence is run with the queue refusing and then accepting. Load data is offered too early and then on time. This separates the store's immediate release from the load's blocking hold. A stray write-back to an empty slot and a simultaneous claim-and-retire near full cover the remaining boundaries.

// File: rtl/rob_commit.sv
module rob_commit #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_rd,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_sdata,
  input  logic              rs_space,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_idx,
  output logic [DATA_W-1:0] rf_data,
  output logic              lsq_valid,
  input  logic              lsq_ready,
  output logic              lsq_is_store,
  output logic [ADDR_W-1:0] lsq_addr,
  output logic [DATA_W-1:0] lsq_wdata,
  output logic [TAG_W-1:0]  lsq_tag,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [1:0] K_ALU = 2'd0, K_LD = 2'd1, K_ST = 2'd2;

  logic              e_valid [DEPTH];
  logic              e_done  [DEPTH];
  logic [1:0]        e_kind  [DEPTH];
  logic [REG_W-1:0]  e_rd    [DEPTH];
  logic [DATA_W-1:0] e_val   [DEPTH];
  logic [ADDR_W-1:0] e_addr  [DEPTH];
  logic [DATA_W-1:0] e_sdata [DEPTH];

  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             ld_sent;

  function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  logic alloc_fire, h_alu, h_ld, h_st, ld_back, retire;

  assign alloc_ready = (int'(count) != DEPTH) && rs_space;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;

  assign h_alu = e_valid[head] && e_kind[head] == K_ALU;
  assign h_ld  = e_valid[head] && e_kind[head] == K_LD;
  assign h_st  = e_valid[head] && e_kind[head] == K_ST;

  assign ld_back = h_ld && ld_sent && mem_rvalid;
  assign retire  = (h_alu && e_done[head]) || (h_st && lsq_ready) || ld_back;

  assign rf_we   = (h_alu && e_done[head]) || ld_back;
  assign rf_idx  = e_rd[head];
  assign rf_data = ld_back ? mem_rdata : e_val[head];

  assign lsq_valid    = h_st || (h_ld && !ld_sent);
  assign lsq_is_store = e_kind[head] == K_ST;
  assign lsq_addr     = e_addr[head];
  assign lsq_wdata    = e_sdata[head];
  assign lsq_tag      = head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      ld_sent <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        e_valid[i] <= 1'b0;
        e_done[i]  <= 1'b0;
        e_kind[i]  <= K_ALU;
        e_rd[i]    <= '0;
        e_val[i]   <= '0;
        e_addr[i]  <= '0;
        e_sdata[i] <= '0;
      end
    end else begin
      if (alloc_fire) begin
        e_valid[tail] <= 1'b1;
        e_done[tail]  <= 1'b0;
        e_kind[tail]  <= alloc_kind;
        e_rd[tail]    <= alloc_rd;
        e_val[tail]   <= '0;
        e_addr[tail]  <= alloc_addr;
        e_sdata[tail] <= alloc_sdata;
        tail          <= step(tail);
      end
      if (wb_valid && e_valid[wb_tag]) begin
        e_done[wb_tag] <= 1'b1;
        e_val[wb_tag]  <= wb_data;
      end
      if (retire) begin
        e_valid[head] <= 1'b0;
        head          <= step(head);
        ld_sent       <= 1'b0;
      end else if (h_ld && lsq_ready && !ld_sent) begin
        ld_sent <= 1'b1;
      end
      count <= count + CNT_W'(alloc_fire) - CNT_W'(retire);
    end
  end
endmodule

module rob_commit_chk #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 3,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic              rf_we,
  input logic              lsq_valid,
  input logic              lsq_ready,
  input logic              lsq_is_store,
  input logic [ADDR_W-1:0] lsq_addr,
  input logic [CNT_W-1:0]  count,
  input logic [TAG_W-1:0]  head
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  p_full_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH) |-> !alloc_ready);

  p_head_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> (head != $past(head)));

  p_offer_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lsq_valid && !lsq_ready) |=> (lsq_valid && $stable(lsq_addr) && $stable(lsq_is_store)));

  p_load_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lsq_valid && lsq_ready && !lsq_is_store) |=> !lsq_valid);

  p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (int'(count) == int'($past(count)) + int'($past(alloc_valid && alloc_ready))
                              - int'($past(rf_we || (lsq_valid && lsq_ready && lsq_is_store)))));
endmodule

bind rob_commit rob_commit_chk #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .rf_we(rf_we), .lsq_valid(lsq_valid), .lsq_ready(lsq_ready),
  .lsq_is_store(lsq_is_store), .lsq_addr(lsq_addr), .count(count), .head(head)
);

// File: tb/rob_commit_tb.sv
`timescale 1ns/1ps
module rob_commit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 0;
  logic [1:0]  alloc_kind = 0;
  logic [2:0]  alloc_rd = 0;
  logic [15:0] alloc_addr = 0, alloc_sdata = 0;
  logic        rs_space = 1;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        wb_valid = 0;
  logic [2:0]  wb_tag = 0;
  logic [15:0] wb_data = 0;
  logic        rf_we;
  logic [2:0]  rf_idx;
  logic [15:0] rf_data;
  logic        lsq_valid, lsq_is_store;
  logic        lsq_ready = 0;
  logic [15:0] lsq_addr, lsq_wdata;
  logic [2:0]  lsq_tag;
  logic        mem_rvalid = 0;
  logic [15:0] mem_rdata = 0;

  always #4 clk = ~clk;

  rob_commit dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_rd(alloc_rd), .alloc_addr(alloc_addr), .alloc_sdata(alloc_sdata),
    .rs_space(rs_space), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
    .lsq_valid(lsq_valid), .lsq_ready(lsq_ready), .lsq_is_store(lsq_is_store),
    .lsq_addr(lsq_addr), .lsq_wdata(lsq_wdata), .lsq_tag(lsq_tag),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int tail = 0;
  bit mon_on = 0;
  int ret_idx = 0, cur_n = 0;
  logic [2:0]  exp_rd  [8];
  logic [15:0] exp_val [8];
  bit          wbd     [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    #1;
    if (mon_on && rf_we) begin
      if (ret_idx < cur_n) begin
        chk(rf_idx == exp_rd[ret_idx] && rf_data == exp_val[ret_idx], "R3",
            "retire order/data", {rf_idx, rf_data}, {exp_rd[ret_idx], exp_val[ret_idx]});
        chk(wbd[ret_idx], "R4", "retired before write-back", 0, 1);
      end else chk(0, "R3", "extra retirement", ret_idx, cur_n);
      ret_idx++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_alloc(input logic [1:0] k, input logic [2:0] rd,
                          input logic [15:0] a, input logic [15:0] d);
    alloc_valid = 1; alloc_kind = k; alloc_rd = rd; alloc_addr = a; alloc_sdata = d;
    cycle();
    alloc_valid = 0;
  endtask

  task automatic do_wb(input int tag, input logic [15:0] d);
    wb_valid = 1; wb_tag = 3'(tag); wb_data = d;
    cycle();
    wb_valid = 0;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(alloc_ready == 1 && alloc_tag == 0 && rf_we == 0 && lsq_valid == 0, "R1", "reset state",
        {alloc_ready, alloc_tag, rf_we, lsq_valid}, {1'b1, 3'd0, 1'b0, 1'b0});
    @(negedge clk);

    // R2: reservation station full blocks allocation
    rs_space = 0; alloc_valid = 1;
    #1 chk(alloc_ready == 0, "R2", "stall on rs_space", alloc_ready, 0);
    cycle();
    alloc_valid = 0; rs_space = 1;
    #1 chk(alloc_tag == 0, "R2", "no claim while stalled", alloc_tag, 0);

    // R2/R3/R4: register-op sweeps
    for (int r = 0; r < 6; r++) begin
      int n, p, k;
      n = (r == 1) ? 5 : (r == 3) ? 3 : 8;
      p = r % 3;
      k = (n % 3 == 0) ? 2 : 3;
      for (int i = 0; i < n; i++) begin
        exp_rd[i]  = 3'((i * 5 + r) % 8);
        exp_val[i] = 16'(16'h1000 * (r + 1) + i * 16'h0123);
        wbd[i] = 0;
      end
      ret_idx = 0; cur_n = n; mon_on = 1;
      for (int i = 0; i < n; i++) begin
        alloc_valid = 1; alloc_kind = 2'd0; alloc_rd = exp_rd[i];
        #1;
        chk(alloc_ready == 1, "R2", "ready while not full", alloc_ready, 1);
        chk(alloc_tag == 3'((tail + i) % 8), "R2", "tag sequence", alloc_tag, (tail + i) % 8);
        cycle();
      end
      alloc_valid = 0;
      #1;
      if (n == 8) chk(alloc_ready == 0, "R2", "full stalls", alloc_ready, 0);
      for (int j = 0; j < n; j++) begin
        int idx;
        idx = (p == 0) ? j : (p == 1) ? n - 1 - j : (j * k) % n;
        wb_valid = 1; wb_tag = 3'((tail + idx) % 8); wb_data = exp_val[idx];
        cycle();
        wbd[idx] = 1;
      end
      wb_valid = 0;
      for (int w = 0; w < 20 && ret_idx < n; w++) cycle();
      chk(ret_idx == n, "R3", "retire count", ret_idx, n);
      mon_on = 0;
      tail = (tail + n) % 8;
    end

    // R5: write-back to an empty slot is ignored
    do_wb(tail, 16'hEEEE);
    do_alloc(2'd0, 3'd3, 0, 0);
    for (int i = 0; i < 3; i++) begin
      #1 chk(rf_we == 0, "R5", "stray write-back completed slot", rf_we, 0);
      cycle();
    end
    do_wb(tail, 16'h7777);
    #1 chk(rf_we && rf_idx == 3 && rf_data == 16'h7777, "R5", "own write-back retires",
           {rf_we, rf_idx, rf_data}, {1'b1, 3'd3, 16'h7777});
    cycle();
    tail = (tail + 1) % 8;

    // R6..R9: store, register op, load, register op
    do_alloc(2'd2, 3'd0, 16'h0A0A, 16'hD00D);
    do_alloc(2'd0, 3'd2, 0, 0);
    do_alloc(2'd1, 3'd5, 16'h0B0B, 0);
    do_alloc(2'd0, 3'd6, 0, 0);
    do_wb((tail + 1) % 8, 16'h1111);
    do_wb((tail + 3) % 8, 16'h3333);
    #1 chk(lsq_valid && lsq_is_store && lsq_addr == 16'h0A0A && lsq_wdata == 16'hD00D
           && lsq_tag == 3'(tail) && !rf_we, "R6", "store offer",
           {lsq_valid, lsq_is_store, lsq_addr, lsq_wdata, lsq_tag},
           {1'b1, 1'b1, 16'h0A0A, 16'hD00D, 3'(tail)});
    for (int i = 0; i < 3; i++) begin
      cycle();
      #1 chk(lsq_valid && lsq_addr == 16'h0A0A && !rf_we, "R7", "offer held while refused",
             {lsq_valid, lsq_addr}, {1'b1, 16'h0A0A});
    end
    lsq_ready = 1;
    cycle();
    lsq_ready = 0;
    #1 chk(rf_we && rf_idx == 2 && rf_data == 16'h1111, "R6", "store released, next retires",
           {rf_we, rf_idx, rf_data}, {1'b1, 3'd2, 16'h1111});
    cycle();
    mem_rvalid = 1; mem_rdata = 16'hBAD0;
    #1 chk(lsq_valid && !lsq_is_store && lsq_addr == 16'h0B0B, "R8", "load offer",
           {lsq_valid, lsq_is_store, lsq_addr}, {1'b1, 1'b0, 16'h0B0B});
    chk(rf_we == 0, "R9", "early data ignored", rf_we, 0);
    cycle();
    mem_rvalid = 0;
    lsq_ready = 1;
    cycle();
    lsq_ready = 0;
    for (int i = 0; i < 2; i++) begin
      #1 chk(!lsq_valid && !rf_we, "R8", "load waits, not reoffered, blocks younger",
             {lsq_valid, rf_we}, 0);
      cycle();
    end
    mem_rvalid = 1; mem_rdata = 16'h4D4D;
    #1 chk(rf_we && rf_idx == 5 && rf_data == 16'h4D4D, "R8", "load data written",
           {rf_we, rf_idx, rf_data}, {1'b1, 3'd5, 16'h4D4D});
    cycle();
    mem_rvalid = 0;
    #1 chk(rf_we && rf_idx == 6 && rf_data == 16'h3333, "R3", "younger retires after load",
           {rf_we, rf_idx, rf_data}, {1'b1, 3'd6, 16'h3333});
    cycle();
    #1 chk(!rf_we && !lsq_valid, "R8", "empty after sequence", {rf_we, lsq_valid}, 0);
    tail = (tail + 4) % 8;

    // R10: claim and retire in the same cycle
    for (int i = 0; i < 7; i++) do_alloc(2'd0, 3'(i), 0, 0);
    do_wb(tail, 16'h0005);
    alloc_valid = 1; alloc_kind = 0; alloc_rd = 3'd7;
    #1 chk(rf_we && alloc_ready, "R10", "simultaneous claim and retire", {rf_we, alloc_ready}, 2'b11);
    cycle();
    #1 chk(alloc_ready == 1, "R10", "occupancy still 7", alloc_ready, 1);
    cycle();
    alloc_valid = 0;
    #1 chk(alloc_ready == 0, "R10", "full at 8", alloc_ready, 0);
    for (int i = 1; i <= 8; i++) do_wb((tail + i) % 8, 16'(i));
    repeat (12) cycle();
    #1 chk(alloc_ready && !rf_we, "R3", "drained", {alloc_ready, rf_we}, 2'b10);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule